// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word clock that marks left and right channel periods, and a data line. It runs entirely in the bit-clock domain. Serial data is always sent MSB first in two's complement and is sampled on the rising edge of the bit clock. A 3-bit format code picks the framing at run time. The framings are right-justified 16, 20 or 24-bit, left-justified 24-bit, and I2S.

Each channel is turned into a 24-bit two's-complement word. Shorter right-justified words are sign-extended. After a left and then a right channel have been captured, both words are presented together on parallel outputs with a one-cycle valid strobe. Left-justified 16 and 20-bit sources use the 24-bit left-justified code, with their unused low bits sent as zeros.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and left_o and right_o are all zeros.
- R2: Code 0 (3'b000): the word is the last 16 bits sampled before the word-clock transition that ends the channel, sign-extended from bit 15. Earlier bits are ignored. A channel needs at least 16 bit clocks.
- R3: Code 1 (3'b001): the same rule with the last 20 bits, sign-extended from bit 19. A channel needs at least 20 bit clocks.
- R4: Code 4 (3'b100): the same rule with the last 24 bits, taken unchanged.
- R5: Code 2 (3'b010): the word is the first 24 bits sampled from the word-clock transition onward, with the first bit as bit 23. Bits after the 24th are ignored.
- R6: Code 3 (3'b011): I2S framing. The left channel is sent while the word clock is low. The MSB is sampled one bit clock after the word-clock transition, and 24 bits are taken as in R5.
- R7: Codes 5, 6 and 7 behave exactly like code 2.
- R8: In codes other than 3, the left channel is sent while the word clock is high. When the rising bit-clock edge that first samples the next left level ends a right channel, valid_o is high in the following cycle. For code 3 it is high one cycle later. valid_o lasts one cycle. left_o and right_o change only together with valid_o.
- R9: The channel in progress at the first word-clock transition after reset is discarded. A right channel with no captured left channel before it produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial bit clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Word clock selecting left/right channel |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 3 | Framing format code |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe: new sample pair |

## Verification
The assertions assume that fmt_i changes only while reset is asserted. They also assume that every channel period holds at least as many bit clocks as the active format needs, so edges always alternate and words are never shorter than their format. The stimulus changes the format only inside a reset and idles the word clock at the right-channel level before each run. It uses only channel periods of 16, 20, 24 and 32 bit clocks, each at or above the minimum for its format. Filler bits are sent as ones to show that they are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned WORD_W = 24;

  typedef enum logic [2:0] {
    FMT_R16 = 3'd0,
    FMT_R20 = 3'd1,
    FMT_L24 = 3'd2,
    FMT_I2S = 3'd3,
    FMT_R24 = 3'd4
  } sar_fmt_e;

  typedef struct packed {
    logic       right_just;
    logic       i2s;
    logic [4:0] bits;
  } sar_cfg_t;

  // unlisted codes fall back to left-justified 24-bit
  function automatic sar_cfg_t sar_decode(input logic [2:0] code);
    sar_cfg_t c;
    c.right_just = 1'b0;
    c.i2s        = 1'b0;
    c.bits       = 5'd24;
    case (code)
      FMT_R16: begin c.right_just = 1'b1; c.bits = 5'd16; end
      FMT_R20: begin c.right_just = 1'b1; c.bits = 5'd20; end
      FMT_R24: c.right_just = 1'b1;
      FMT_I2S: c.i2s = 1'b1;
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sar_wclk_edge.sv
module sar_wclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  input  logic i2s_i,
  output logic edge_o,
  output logic ended_left_o
);
  logic       lr_q, lr_qq;
  logic [1:0] warm_q;
  logic       wc_now, wc_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q   <= 1'b0;
      lr_qq  <= 1'b0;
      warm_q <= 2'd0;
    end else begin
      lr_q  <= lrck_i;
      lr_qq <= lr_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  // I2S: word clock delayed one bit and inverted, so left is high in both cases
  always_comb begin
    wc_now  = i2s_i ? ~lr_q  : lrck_i;
    wc_prev = i2s_i ? ~lr_qq : lr_q;
  end

  assign edge_o       = (warm_q == 2'd2) && (wc_now != wc_prev);
  assign ended_left_o = wc_prev;
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                edge_i,
  output logic [SAMPLE_W-1:0] tail_o,
  output logic [SAMPLE_W-1:0] head_o
);
  logic [SAMPLE_W-1:0] tail_q, head_q;
  logic [CNT_W-1:0]    fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      head_q <= '0;
      fill_q <= '0;
    end else begin
      tail_q <= {tail_q[SAMPLE_W-2:0], sdata_i};
      if (edge_i) begin
        head_q <= {{(SAMPLE_W-1){1'b0}}, sdata_i};
        fill_q <= CNT_W'(1);
      end else if (fill_q < CNT_W'(SAMPLE_W)) begin
        head_q <= {head_q[SAMPLE_W-2:0], sdata_i};
        fill_q <= fill_q + CNT_W'(1);
      end
    end
  end

  assign tail_o = tail_q;
  assign head_o = head_q;
endmodule

// File: rtl/sar_word_select.sv
module sar_word_select #(
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1)
) (
  input  sar_pkg::sar_cfg_t   cfg_i,
  input  logic [SAMPLE_W-1:0] tail_i,
  input  logic [SAMPLE_W-1:0] head_i,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [CNT_W-1:0]    amt;
  logic [SAMPLE_W-1:0] up;

  always_comb begin
    amt = CNT_W'(SAMPLE_W) - CNT_W'(cfg_i.bits);
    up  = tail_i << amt;
    if (cfg_i.right_just) word_o = SAMPLE_W'($signed(up) >>> amt);
    else                  word_o = head_i;
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int unsigned SAMPLE_W = sar_pkg::WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lrck_i,
  input  logic                sdata_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  sar_pkg::sar_cfg_t   cfg;
  logic                wclk_edge, ended_left;
  logic [SAMPLE_W-1:0] tail, head, word;
  logic [SAMPLE_W-1:0] left_stage_q;
  logic                armed_q, got_left_q;

  assign cfg = sar_pkg::sar_decode(fmt_i);

  sar_wclk_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lrck_i      (lrck_i),
    .i2s_i       (cfg.i2s),
    .edge_o      (wclk_edge),
    .ended_left_o(ended_left)
  );

  sar_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdata_i(sdata_i),
    .edge_i (wclk_edge),
    .tail_o (tail),
    .head_o (head)
  );

  sar_word_select #(.SAMPLE_W(SAMPLE_W)) u_sel (
    .cfg_i (cfg),
    .tail_i(tail),
    .head_i(head),
    .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b0;
      got_left_q   <= 1'b0;
      left_stage_q <= '0;
      left_o       <= '0;
      right_o      <= '0;
      valid_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (wclk_edge) begin
        if (!armed_q) begin
          armed_q    <= 1'b1;   // first channel is partial
          got_left_q <= 1'b0;
        end else if (ended_left) begin
          left_stage_q <= word;
          got_left_q   <= 1'b1;
        end else begin
          got_left_q <= 1'b0;
          if (got_left_q) begin
            left_o  <= left_stage_q;
            right_o <= word;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          fmt_i,
  input logic                edge_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && left_o == '0 && right_o == '0));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r8_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(edge_i));

  a_r2_sext16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) == 3'd0) |->
      ($countones(right_o[SAMPLE_W-1:15]) == 0 ||
       $countones(right_o[SAMPLE_W-1:15]) == SAMPLE_W - 15));

  a_r3_sext20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) == 3'd1) |->
      ($countones(right_o[SAMPLE_W-1:19]) == 0 ||
       $countones(right_o[SAMPLE_W-1:19]) == SAMPLE_W - 19));
endmodule

bind serial_audio_rx sar_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fmt_i  (fmt_i),
  .edge_i (wclk_edge),
  .left_o (left_o),
  .right_o(right_o),
  .valid_o(valid_o)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0, checks = 0;
  int cyc = 0;
  int left_cyc = 0;
  int lat = 1;
  logic carry = 1'b1;
  logic [23:0] exp_l [0:255];
  logic [23:0] exp_r [0:255];
  int wr_ptr = 0, rd_ptr = 0;
  logic [23:0] prev_l = '0, prev_r = '0;
  logic        prev_v = 1'b0;

  serial_audio_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit is_i2s(input logic [2:0] f); return f == 3'd3; endfunction
  function automatic bit is_rj(input logic [2:0] f);
    return f == 3'd0 || f == 3'd1 || f == 3'd4;
  endfunction
  function automatic int width_of(input logic [2:0] f);
    return f == 3'd0 ? 16 : (f == 3'd1 ? 20 : 24);
  endfunction
  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic [23:0] m;
    m = (24'h1 << n) - 24'h1;
    return v[n-1] ? ((v & m) | ~m) : (v & m);
  endfunction
  function automatic logic [23:0] sample(input int i, input int n);
    if (i % 7 == 0) return 24'h1 << (n - 1);
    if (i % 7 == 1) return (24'h1 << (n - 1)) - 24'h1;
    if (i % 7 == 2) return 24'hFFFFFF;
    return 24'(i * 32'h3B5D1 + 32'h91E7);
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd4: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // monitor: R8 timing/hold, data against expectation queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        check(!prev_v, "R8 pulse", 24'(prev_v), 24'd0);
        check(cyc - left_cyc == lat, "R8 latency", 24'(cyc - left_cyc), 24'(lat));
        if (rd_ptr == wr_ptr) begin
          check(1'b0, "R9 unexpected valid", 24'd1, 24'd0);
        end else begin
          check(left_o == exp_l[rd_ptr % 256], {tag_of(fmt), " left"}, left_o, exp_l[rd_ptr % 256]);
          check(right_o == exp_r[rd_ptr % 256], {tag_of(fmt), " right"}, right_o, exp_r[rd_ptr % 256]);
          rd_ptr++;
        end
      end else begin
        if (left_o != prev_l || right_o != prev_r)
          check(1'b0, "R8 hold", left_o, prev_l);
      end
    end
    prev_l = left_o;
    prev_r = right_o;
    prev_v = valid_o;
  end

  task automatic emit(input logic lv, input logic b, input bit mark);
    @(negedge clk);
    lrck = lv;
    if (is_i2s(fmt)) begin
      sdata = carry;
      carry = b;
    end else begin
      sdata = b;
    end
    if (mark) left_cyc = cyc;
  endtask

  task automatic send_ch(input bit is_left, input int b, input logic [23:0] v);
    logic lv;
    int n;
    logic bitv;
    lv = is_i2s(fmt) ? ~is_left : is_left;
    n = width_of(fmt);
    for (int k = 0; k < b; k++) begin
      if (is_rj(fmt)) bitv = (k < b - n) ? 1'b1 : v[n - 1 - (k - (b - n))];
      else            bitv = (k < 24) ? v[23 - k] : 1'b1;
      emit(lv, bitv, is_left && k == 0);
    end
  endtask

  task automatic send_frame(input int b, input logic [23:0] lv, input logic [23:0] rv);
    send_ch(1'b1, b, lv);
    send_ch(1'b0, b, rv);
    exp_l[wr_ptr % 256] = is_rj(fmt) ? sx(lv, width_of(fmt)) : lv;
    exp_r[wr_ptr % 256] = is_rj(fmt) ? sx(rv, width_of(fmt)) : rv;
    wr_ptr++;
  endtask

  task automatic tail_out();
    for (int k = 0; k < 4; k++) emit(is_i2s(fmt) ? 1'b0 : 1'b1, 1'b1, k == 0);
    repeat (4) @(negedge clk);
    check(rd_ptr == wr_ptr, {tag_of(fmt), " frame count"}, 24'(rd_ptr), 24'(wr_ptr));
  endtask

  task automatic do_reset(input logic [2:0] f, input logic idle_lv);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f;
    lrck = idle_lv;
    sdata = 1'b0;
    carry = 1'b1;
    lat = is_i2s(f) ? 2 : 1;
    rd_ptr = 0;
    wr_ptr = 0;
    repeat (3) @(negedge clk);
    check(!valid_o && left_o == '0 && right_o == '0, "R1 reset", left_o | right_o, 24'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (2) @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      int bmin;
      bmin = is_rj(3'(f)) ? width_of(3'(f)) : 24;
      for (int bsel = 0; bsel < 2; bsel++) begin
        int b;
        b = bsel == 0 ? bmin : 32;
        do_reset(3'(f), is_i2s(3'(f)) ? 1'b1 : 1'b0);
        for (int i = 0; i < 6; i++) begin
          send_frame(b, sample(seed, width_of(3'(f))), sample(seed + 3, width_of(3'(f))));
          seed++;
        end
        tail_out();
      end
    end
    // R9: start mid-left, then an orphan right channel
    do_reset(3'd2, 1'b1);
    for (int k = 0; k < 5; k++) emit(1'b1, 1'b0, 1'b0);
    send_ch(1'b0, 24, 24'h123456);
    for (int i = 0; i < 3; i++) send_frame(32, sample(i + 40, 24), sample(i + 50, 24));
    tail_out();
    // R9 with I2S: partial left then orphan right
    do_reset(3'd3, 1'b0);
    for (int k = 0; k < 7; k++) emit(1'b0, 1'b1, 1'b0);
    send_ch(1'b0, 24, 24'hABCDEF);
    for (int i = 0; i < 3; i++) send_frame(24, sample(i + 60, 24), sample(i + 70, 24));
    tail_out();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule